// File: doc/BRIEF.md
# Flash Write/Erase Sequencer

This block is the host-side master for a byte-wide parallel flash that has asynchronous chip-enable, output-enable and write-enable strobes. A client hands it one operation at a time through a valid/ready request port: a plain byte read, a byte program, a sector erase or a whole-chip erase. For the write-type operations the sequencer produces the unlock and command write cycles, with a setup phase and a write pulse whose lengths are set in clock cycles. It then reads the device back to find out when the internal operation has finished.

Completion is found by polling the device rather than by waiting a fixed time. Each operation can choose one of two methods. In the first, bit 7 of the polled byte is watched until it equals bit 7 of the expected value. In the second, two reads in a row are compared and the operation is finished once bit 6 no longer changes. A cycle-count watchdog, with one limit for programs and another for erases, gives up on an operation that never finishes. Before a program, the target byte is read so that a request that would have to turn a 0 into a 1 is rejected. After completion, an optional read compares the whole byte against the expected value.

Top module: `flash_seq`

## Requirements
- R1: `req_ready` is high only while the sequencer is idle. After a request is accepted it stays low until the one-cycle `rsp_valid` pulse, and it is high again in the cycle after that pulse.
- R2: Operation code 00 (read) makes exactly one read cycle at `req_addr`, with no write strobe. It responds with status 00 (ok) and the byte on `rsp_rdata`.
- R3: Operation code 01 (program) issues exactly four write cycles, in this order: 0xAA to 0x5555, 0x55 to 0x2AAA, 0xA0 to 0x5555, then the data to `req_addr`.
- R4: Operation code 10 (sector erase) issues exactly six write cycles: 0xAA/0x5555, 0x55/0x2AAA, 0x80/0x5555, 0xAA/0x5555, 0x55/0x2AAA, then 0x30 to `req_addr`.
- R5: Operation code 11 (chip erase) issues the same first five cycles as R4, and its sixth cycle is 0x10 to 0x5555.
- R6: During a write cycle, WE is low only while CE is low, OE is high and the data bus is driven. Address and data do not change while WE is low. CE is low with WE high for at least SETUP_CYC cycles before WE falls.
- R7: In bit-7 polling mode (`cfg_toggle_poll`=0), the polled address is re-read until bit 7 equals bit 7 of the expected byte. The expected byte is the program data, or 0xFF for an erase. The operation then ends with status ok, and `rsp_rdata` holds that last read.
- R8: In toggle mode (`cfg_toggle_poll`=1), the operation completes only when bit 6 is equal in two successive polled reads.
- R9: A program whose data has a 1 where the current byte has a 0 responds with status 01 (error) and issues no write cycle.
- R10: If a poll is still unfinished after `prog_limit` cycles (for a program) or `erase_limit` cycles (for an erase) spent polling, the response carries status 10 (timeout). Each limit applies only to its own kind of operation.
- R11: With `cfg_verify`=1, a completed program or erase reads the address once more. It responds with status ok if the full byte equals the expected byte, and with error otherwise. Status 11 is never reported.
- R12: While reset is active, the next cycle shows `req_ready`=1, CE, OE and WE all high, and `rsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request taken when valid |
| req_op | input | 2 | 00 read, 01 program, 10 sector erase, 11 chip erase |
| req_addr | input | AW | Target byte or sector address |
| req_data | input | 8 | Byte to program |
| cfg_toggle_poll | input | 1 | 0 bit-7 polling, 1 toggle polling (taken with request) |
| cfg_verify | input | 1 | Enable final verify read (taken with request) |
| prog_limit | input | WDW | Poll cycle limit for programs |
| erase_limit | input | WDW | Poll cycle limit for erases |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_status | output | 2 | 00 ok, 01 error, 10 timeout |
| rsp_rdata | output | 8 | Last byte read from the device |
| fl_addr | output | AW | Flash address |
| fl_wdata | output | 8 | Flash write data |
| fl_data_oe | output | 1 | Drive enable for the data bus |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_we_n | output | 1 | Write enable, active low |
| fl_rdata | input | 8 | Data returned by the flash |

## Verification
If the sequence step counter is corrupted, the bus shows a wrong address/data pair or a wrong number of WE pulses in the very next write cycle, and that can be compared entry by entry against the command list. If the polling decision is wrong, the response either comes while the device model is still busy, which shows as a wrong `rsp_rdata`, or never comes until the watchdog status appears. Both are visible in the same transaction. A broken precheck or verify shows up directly as a wrong `rsp_status`, or as unexpected write pulses, on that request.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [1:0] {
        OP_READ = 2'b00,
        OP_PROG = 2'b01,
        OP_SECT = 2'b10,
        OP_CHIP = 2'b11
    } fop_e;

    typedef enum logic [1:0] {
        STS_OK  = 2'b00,
        STS_ERR = 2'b01,
        STS_TMO = 2'b10
    } fsts_e;

    typedef enum logic [1:0] {
        B_IDLE,
        B_SETUP,
        B_ACT,
        B_HOLD
    } bst_e;

    typedef enum logic [2:0] {
        T_IDLE,
        T_RD,
        T_PRE,
        T_CMD,
        T_POLL,
        T_VER,
        T_RSP
    } tst_e;

    localparam logic [15:0] UNLK_A1 = 16'h5555;
    localparam logic [15:0] UNLK_A2 = 16'h2AAA;
    localparam logic [7:0]  KEY1    = 8'hAA;
    localparam logic [7:0]  KEY2    = 8'h55;
    localparam logic [7:0]  CMD_PGM = 8'hA0;
    localparam logic [7:0]  CMD_ERS = 8'h80;
    localparam logic [7:0]  CMD_SEC = 8'h30;
    localparam logic [7:0]  CMD_ALL = 8'h10;
    localparam logic [7:0]  ERASED  = 8'hFF;

    typedef struct packed {
        logic [15:0] a;
        logic [7:0]  d;
        logic        use_req;
    } cmd_t;

    function automatic logic [2:0] cmd_last(fop_e op);
        return (op == OP_PROG) ? 3'd3 : 3'd5;
    endfunction

    function automatic cmd_t cmd_at(fop_e op, logic [2:0] step, logic [7:0] d);
        cmd_t c;
        c.a = UNLK_A1;
        c.d = KEY1;
        c.use_req = 1'b0;
        case (step)
            3'd1: begin c.a = UNLK_A2; c.d = KEY2; end
            3'd2: c.d = (op == OP_PROG) ? CMD_PGM : CMD_ERS;
            3'd3: if (op == OP_PROG) begin c.use_req = 1'b1; c.d = d; end
            3'd4: begin c.a = UNLK_A2; c.d = KEY2; end
            3'd5: begin
                if (op == OP_SECT) begin c.use_req = 1'b1; c.d = CMD_SEC; end
                else c.d = CMD_ALL;
            end
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/flash_bus_cyc.sv
module flash_bus_cyc
    import flash_seq_pkg::*;
#(
    parameter int AW        = 18,
    parameter int SETUP_CYC = 2,
    parameter int PULSE_CYC = 3,
    parameter int READ_CYC  = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          start_wr,
    input  logic [AW-1:0] start_addr,
    input  logic [7:0]    start_data,
    output logic          done,
    output logic [7:0]    rd_byte,
    output logic [AW-1:0] fl_addr,
    output logic [7:0]    fl_wdata,
    output logic          fl_data_oe,
    output logic          fl_ce_n,
    output logic          fl_oe_n,
    output logic          fl_we_n,
    input  logic [7:0]    fl_rdata
);
    localparam int MAXA = (PULSE_CYC > READ_CYC) ? PULSE_CYC : READ_CYC;
    localparam int MAXC = (SETUP_CYC > MAXA) ? SETUP_CYC : MAXA;
    localparam int CW   = $clog2(MAXC + 1);

    bst_e          st;
    logic [CW-1:0] cnt;
    logic          wr_q;
    logic [AW-1:0] addr_q;
    logic [7:0]    data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= B_IDLE;
            cnt     <= '0;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
            done    <= 1'b0;
            rd_byte <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                B_IDLE: if (start) begin
                    st     <= B_SETUP;
                    cnt    <= CW'(SETUP_CYC - 1);
                    wr_q   <= start_wr;
                    addr_q <= start_addr;
                    data_q <= start_data;
                end
                B_SETUP: begin
                    if (cnt == '0) begin
                        st  <= B_ACT;
                        cnt <= wr_q ? CW'(PULSE_CYC - 1) : CW'(READ_CYC - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                B_ACT: begin
                    if (cnt == '0) begin
                        st <= B_HOLD;
                        if (!wr_q) rd_byte <= fl_rdata;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                B_HOLD: begin
                    st   <= B_IDLE;
                    done <= 1'b1;
                end
                default: st <= B_IDLE;
            endcase
        end
    end

    always_comb begin
        fl_addr    = addr_q;
        fl_wdata   = data_q;
        fl_ce_n    = (st == B_IDLE);
        fl_oe_n    = !((st == B_ACT) && !wr_q);
        fl_we_n    = !((st == B_ACT) && wr_q);
        fl_data_oe = wr_q && (st != B_IDLE);
    end

endmodule

// File: rtl/flash_wd.sv
module flash_wd #(
    parameter int WDW = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clear,
    input  logic           run,
    input  logic [WDW-1:0] limit,
    output logic           expired
);
    logic [WDW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) cnt <= '0;
        else if (run && (cnt != '1)) cnt <= cnt + 1'b1;
    end

    assign expired = (cnt >= limit);

endmodule

// File: rtl/flash_seq.sv
module flash_seq
    import flash_seq_pkg::*;
#(
    parameter int AW        = 18,
    parameter int WDW       = 16,
    parameter int SETUP_CYC = 2,
    parameter int PULSE_CYC = 3,
    parameter int READ_CYC  = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           req_valid,
    output logic           req_ready,
    input  logic [1:0]     req_op,
    input  logic [AW-1:0]  req_addr,
    input  logic [7:0]     req_data,
    input  logic           cfg_toggle_poll,
    input  logic           cfg_verify,
    input  logic [WDW-1:0] prog_limit,
    input  logic [WDW-1:0] erase_limit,
    output logic           rsp_valid,
    output logic [1:0]     rsp_status,
    output logic [7:0]     rsp_rdata,
    output logic [AW-1:0]  fl_addr,
    output logic [7:0]     fl_wdata,
    output logic           fl_data_oe,
    output logic           fl_ce_n,
    output logic           fl_oe_n,
    output logic           fl_we_n,
    input  logic [7:0]     fl_rdata
);
    tst_e          st;
    fop_e          op_q;
    logic [AW-1:0] addr_q;
    logic [7:0]    data_q;
    logic          tgl_q, ver_q;
    logic [2:0]    step_q;
    logic          pend_q;
    logic          have_prev_q, prev6_q;
    fsts_e         sts_q;
    logic [7:0]    rd_q;

    logic          bus_start, bus_wr, bus_done;
    logic [AW-1:0] bus_addr;
    logic [7:0]    bus_data, bus_rd;
    cmd_t          cmd;
    logic [7:0]    exp_byte;
    logic          poll_hit;
    logic          wd_run, wd_exp;

    assign cmd      = cmd_at(op_q, step_q, data_q);
    assign exp_byte = (op_q == OP_PROG) ? data_q : ERASED;
    assign poll_hit = tgl_q ? (have_prev_q && (bus_rd[6] == prev6_q))
                            : (bus_rd[7] == exp_byte[7]);

    always_comb begin
        bus_start = !pend_q && (st inside {T_RD, T_PRE, T_CMD, T_POLL, T_VER});
        bus_wr    = (st == T_CMD);
        bus_data  = cmd.d;
        if (st == T_CMD && !cmd.use_req) bus_addr = AW'(cmd.a);
        else                             bus_addr = addr_q;
    end

    assign wd_run = (st == T_POLL);

    flash_bus_cyc #(
        .AW(AW), .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .READ_CYC(READ_CYC)
    ) u_bus (
        .clk(clk), .rst(rst),
        .start(bus_start), .start_wr(bus_wr),
        .start_addr(bus_addr), .start_data(bus_data),
        .done(bus_done), .rd_byte(bus_rd),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_data_oe(fl_data_oe),
        .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n),
        .fl_rdata(fl_rdata)
    );

    flash_wd #(.WDW(WDW)) u_wd (
        .clk(clk), .rst(rst),
        .clear(!wd_run), .run(wd_run),
        .limit((op_q == OP_PROG) ? prog_limit : erase_limit),
        .expired(wd_exp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= T_IDLE;
            op_q        <= OP_READ;
            addr_q      <= '0;
            data_q      <= '0;
            tgl_q       <= 1'b0;
            ver_q       <= 1'b0;
            step_q      <= '0;
            pend_q      <= 1'b0;
            have_prev_q <= 1'b0;
            prev6_q     <= 1'b0;
            sts_q       <= STS_OK;
            rd_q        <= '0;
        end else begin
            if (bus_start)     pend_q <= 1'b1;
            else if (bus_done) pend_q <= 1'b0;
            case (st)
                T_IDLE: if (req_valid) begin
                    op_q   <= fop_e'(req_op);
                    addr_q <= req_addr;
                    data_q <= req_data;
                    tgl_q  <= cfg_toggle_poll;
                    ver_q  <= cfg_verify;
                    step_q <= '0;
                    case (fop_e'(req_op))
                        OP_READ: st <= T_RD;
                        OP_PROG: st <= T_PRE;
                        default: st <= T_CMD;
                    endcase
                end
                T_RD: if (bus_done) begin
                    rd_q  <= bus_rd;
                    sts_q <= STS_OK;
                    st    <= T_RSP;
                end
                T_PRE: if (bus_done) begin
                    rd_q <= bus_rd;
                    if ((~bus_rd & data_q) != 8'h00) begin
                        sts_q <= STS_ERR;
                        st    <= T_RSP;
                    end else begin
                        st <= T_CMD;
                    end
                end
                T_CMD: if (bus_done) begin
                    if (step_q == cmd_last(op_q)) begin
                        st          <= T_POLL;
                        have_prev_q <= 1'b0;
                    end else begin
                        step_q <= step_q + 1'b1;
                    end
                end
                T_POLL: if (bus_done) begin
                    rd_q        <= bus_rd;
                    prev6_q     <= bus_rd[6];
                    have_prev_q <= 1'b1;
                    if (poll_hit) begin
                        if (ver_q) st <= T_VER;
                        else begin
                            sts_q <= STS_OK;
                            st    <= T_RSP;
                        end
                    end else if (wd_exp) begin
                        sts_q <= STS_TMO;
                        st    <= T_RSP;
                    end
                end
                T_VER: if (bus_done) begin
                    rd_q  <= bus_rd;
                    sts_q <= (bus_rd == exp_byte) ? STS_OK : STS_ERR;
                    st    <= T_RSP;
                end
                T_RSP: st <= T_IDLE;
                default: st <= T_IDLE;
            endcase
        end
    end

    assign req_ready  = (st == T_IDLE);
    assign rsp_valid  = (st == T_RSP);
    assign rsp_status = sts_q;
    assign rsp_rdata  = rd_q;

endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk #(
    parameter int AW        = 18,
    parameter int SETUP_CYC = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic [1:0]    rsp_status,
    input logic [AW-1:0] fl_addr,
    input logic [7:0]    fl_wdata,
    input logic          fl_data_oe,
    input logic          fl_ce_n,
    input logic          fl_oe_n,
    input logic          fl_we_n
);
    logic [7:0] setup_cnt;

    always_ff @(posedge clk) begin
        if (rst || fl_ce_n || !fl_we_n) setup_cnt <= '0;
        else if (setup_cnt != 8'hFF)    setup_cnt <= setup_cnt + 1'b1;
    end

    // R12
    rst_idle_chk: assert property (@(posedge clk)
        rst |=> (req_ready && fl_ce_n && fl_oe_n && fl_we_n && !rsp_valid));

    // R1
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R1
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> (!rsp_valid && req_ready));

    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !fl_we_n |-> (!fl_ce_n && fl_oe_n && fl_data_oe));

    // R6
    wr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_wdata)));

    // R6
    setup_time_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(fl_we_n) |-> (setup_cnt >= SETUP_CYC));

    // R2
    read_no_we_chk: assert property (@(posedge clk) disable iff (rst)
        !fl_oe_n |-> (fl_we_n && !fl_ce_n && !fl_data_oe));

    // R11
    sts_legal_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_status != 2'b11));

endmodule

bind flash_seq flash_seq_chk #(.AW(AW), .SETUP_CYC(SETUP_CYC)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_data_oe(fl_data_oe),
    .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
);

// File: tb/flash_seq_tb.sv
module flash_seq_tb;
    localparam int AW  = 18;
    localparam int WDW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_data = '0;
    logic          cfg_toggle_poll = 1'b0;
    logic          cfg_verify = 1'b0;
    logic [WDW-1:0] prog_limit = 16'd2000;
    logic [WDW-1:0] erase_limit = 16'd2000;
    logic          rsp_valid;
    logic [1:0]    rsp_status;
    logic [7:0]    rsp_rdata;
    logic [AW-1:0] fl_addr;
    logic [7:0]    fl_wdata;
    logic          fl_data_oe, fl_ce_n, fl_oe_n, fl_we_n;
    logic [7:0]    fl_rdata;

    always #2.5 clk = ~clk;

    flash_seq u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
        .cfg_toggle_poll(cfg_toggle_poll), .cfg_verify(cfg_verify),
        .prog_limit(prog_limit), .erase_limit(erase_limit),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_rdata(rsp_rdata),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_data_oe(fl_data_oe),
        .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n),
        .fl_rdata(fl_rdata)
    );

    // ---------------- flash device model ----------------
    int            busy_len = 0;
    bit            corrupt = 1'b0;
    bit            stuck_clear = 1'b0;
    int            busy_left;
    logic          tog, exp7, we_prev, oe_prev;
    logic [7:0]    mem [256];
    logic [AW-1:0] wlog_a [1024];
    logic [7:0]    wlog_d [1024];
    int            wcnt;
    int            r6_bad;
    logic [AW-1:0] fall_a;
    logic [7:0]    fall_d;

    always @(negedge clk) begin
        if (rst) begin
            busy_left = 0; tog = 1'b0; exp7 = 1'b1; wcnt = 0; r6_bad = 0;
            we_prev = 1'b1; oe_prev = 1'b1; fall_a = '0; fall_d = '0;
            for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
        end else begin
            if (stuck_clear) busy_left = 0;
            else if (busy_left > 0) busy_left--;
            if (oe_prev && !fl_oe_n) tog = ~tog;
            if (we_prev && !fl_we_n) begin fall_a = fl_addr; fall_d = fl_wdata; end
            if (!we_prev && fl_we_n) begin
                if (fl_ce_n || fl_addr != fall_a || fl_wdata != fall_d) r6_bad++;
                wlog_a[wcnt] = fl_addr;
                wlog_d[wcnt] = fl_wdata;
                wcnt++;
                if (wcnt >= 4 && wlog_d[wcnt-2] == 8'hA0 && wlog_d[wcnt-3] == 8'h55 &&
                    wlog_d[wcnt-4] == 8'hAA) begin
                    mem[fl_addr[7:0]] = fl_wdata ^ {7'd0, corrupt};
                    exp7 = fl_wdata[7];
                    busy_left = busy_len;
                end else if (wcnt >= 6 && wlog_d[wcnt-4] == 8'h80 &&
                             (fl_wdata == 8'h30 || fl_wdata == 8'h10)) begin
                    for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
                    exp7 = 1'b1;
                    busy_left = busy_len;
                end
            end
            we_prev = fl_we_n;
            oe_prev = fl_oe_n;
        end
    end

    assign fl_rdata = (busy_left != 0) ? {~exp7, tog, 6'b0} : mem[fl_addr[7:0]];

    // ---------------- bench bookkeeping ----------------
    int         nchk = 0, nfail = 0;
    bit         finished = 1'b0;
    logic [7:0] shadow [256];

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
        end
    endtask

    function automatic logic [25:0] exp_wr(int op, int i, logic [AW-1:0] a, logic [7:0] d);
        logic [AW-1:0] ua1 = 18'h05555, ua2 = 18'h02AAA;
        case (i)
            0: return {ua1, 8'hAA};
            1: return {ua2, 8'h55};
            2: return {ua1, (op == 1) ? 8'hA0 : 8'h80};
            3: return (op == 1) ? {a, d} : {ua1, 8'hAA};
            4: return {ua2, 8'h55};
            default: return (op == 2) ? {a, 8'h30} : {ua1, 8'h10};
        endcase
    endfunction

    task automatic run_op(input int op, input logic [AW-1:0] a, input logic [7:0] d,
                          input bit tgl, input bit ver, input int blen,
                          input logic [1:0] exp_sts, input string tag);
        int base, nwr;
        bit seq_ok;
        logic [7:0] pre;
        pre = shadow[a[7:0]];
        busy_len = blen;
        base = wcnt;
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'(op); req_addr = a; req_data = d;
        cfg_toggle_poll = tgl; cfg_verify = ver;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, {tag, " R1 ready low while busy"}, req_ready, 0);
        while (!rsp_valid) @(negedge clk);
        check(rsp_status == exp_sts, {tag, " status"}, rsp_status, exp_sts);
        nwr = (op == 0) ? 0 : (op == 1) ? (((~pre & d) != 0) ? 0 : 4) : 6;
        check(wcnt - base == nwr, {tag, " write count"}, wcnt - base, nwr);
        seq_ok = 1'b1;
        for (int i = 0; i < nwr; i++)
            if ({wlog_a[base+i], wlog_d[base+i]} != exp_wr(op, i, a, d)) seq_ok = 1'b0;
        if (nwr != 0) check(seq_ok, {tag, " command sequence"}, {30'd0, seq_ok}, 1);
        if (op == 0)
            check(rsp_rdata == pre, {tag, " R2 read data"}, rsp_rdata, pre);
        if (op == 1 && nwr == 4) shadow[a[7:0]] = d ^ {7'd0, corrupt};
        if (op >= 2) for (int i = 0; i < 256; i++) shadow[i] = 8'hFF;
        if (op != 0 && exp_sts == 2'b00 && !ver) begin
            logic [7:0] e;
            e = (op == 1) ? d : 8'hFF;
            check(rsp_rdata == e, {tag, " R7/R8 final poll data"}, rsp_rdata, e);
        end
        @(negedge clk);
        check(req_ready && !rsp_valid, {tag, " R1 ready after response"}, req_ready, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            nchk++; nfail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) shadow[i] = 8'hFF;
        repeat (4) @(negedge clk);
        // R12 reset state
        check(req_ready && fl_ce_n && fl_oe_n && fl_we_n && !rsp_valid,
              "R12 reset idle", {req_ready, fl_ce_n, fl_oe_n, fl_we_n, rsp_valid}, 5'b11110);
        rst = 1'b0;
        @(negedge clk);

        // R5 chip erase, bit-7 polling (R7)
        run_op(3, 18'h00010, 8'h00, 1'b0, 1'b0, 20, 2'b00, "R5 R7 chip erase");
        // R3 program, toggle polling (R8)
        run_op(1, 18'h00123, 8'h5A, 1'b1, 1'b0, 15, 2'b00, "R3 R8 program toggle");
        // R2 read back
        run_op(0, 18'h00123, 8'h00, 1'b0, 1'b0, 0, 2'b00, "R2 read");
        // R4 sector erase at top sector
        run_op(2, 18'h3C000, 8'h00, 1'b1, 1'b1, 25, 2'b00, "R4 sector erase");
        // R7 program with bit-7 polling and a long busy time
        run_op(1, 18'h000C1, 8'h3C, 1'b0, 1'b0, 40, 2'b00, "R7 program bit7");
        // R9 precheck error
        run_op(1, 18'h00044, 8'h00, 1'b0, 1'b0, 5, 2'b00, "R9 setup zero");
        run_op(1, 18'h00044, 8'h0F, 1'b0, 1'b0, 5, 2'b01, "R9 zero-to-one rejected");
        // R10 program timeout, erase limit unaffected
        prog_limit = 16'd40; erase_limit = 16'd3000;
        run_op(1, 18'h00077, 8'h80, 1'b0, 1'b0, 100000, 2'b10, "R10 program timeout");
        stuck_clear = 1'b1; @(negedge clk); stuck_clear = 1'b0;
        run_op(2, 18'h20000, 8'h00, 1'b0, 1'b0, 80, 2'b00, "R10 erase uses own limit");
        // R10 erase timeout
        prog_limit = 16'd3000; erase_limit = 16'd40;
        run_op(3, 18'h00000, 8'h00, 1'b1, 1'b0, 100000, 2'b10, "R10 erase timeout");
        stuck_clear = 1'b1; @(negedge clk); stuck_clear = 1'b0;
        prog_limit = 16'd2000; erase_limit = 16'd2000;
        // R11 verify mismatch and match
        corrupt = 1'b1;
        run_op(1, 18'h00033, 8'hF0, 1'b0, 1'b1, 10, 2'b01, "R11 verify mismatch");
        corrupt = 1'b0;
        run_op(1, 18'h00055, 8'h96, 1'b1, 1'b1, 10, 2'b00, "R11 verify match");

        // constrained random mix
        for (int n = 0; n < 60; n++) begin
            int op, bl;
            logic [AW-1:0] a;
            logic [7:0] d;
            bit t, v;
            op = (($urandom % 8) == 0) ? 2 + ($urandom % 2) : ($urandom % 2);
            a  = AW'($urandom);
            d  = shadow[a[7:0]] & 8'($urandom);
            t  = 1'($urandom);
            v  = 1'($urandom);
            bl = $urandom % 30;
            run_op(op, a, d, t, v, bl, 2'b00, "random");
        end

        check(r6_bad == 0, "R6 write strobes stable", r6_bad, 0);
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule